// File: doc/BRIEF.md
# Wake-Aware Interrupt Status Controller

This block keeps the interrupt status register of a transceiver companion chip and drives the active-low interrupt line as an open-drain enable. Each status bit is set by a single-cycle event pulse. The sources are the CAN wake detector, one wake detector per LIN channel, one qualified event per local wake pin, and a cyclic source tied to the watchdog. Software reads the register through a plain read port. It clears bits by writing ones through a write strobe.

The CAN and LIN wake sources each also keep a pending-wake flag for the mode controller. A write-1 clear of the status bit does not touch that flag. The flag drops only when the system enters Normal mode while the standby control bit of that channel is 0. Because of this, a wake that software acknowledges in Standby still counts as a wake.

The cyclic interrupt is armed when the watchdog moves into its timeout mode. This arming happens only while the system is in Standby or Normal and the watchdog-off input is low. While armed, every watchdog overflow pulse raises the cyclic status bit.

Top module: `isc_irq_ctrl`

## Requirements
- R1: `irq_pull_low` is 1 exactly while at least one status bit is 1, and 0 (released) otherwise.
- R2: A cycle with `reg_wr`=1 clears every status bit whose `reg_wdata` bit is 1, visible one cycle later. Bits written with 0 keep their value.
- R3: If an event pulse and a write-1 clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R4: `reg_rdata` returns the status bits with this layout: bit 0 CAN wake, bits 1..NUM_LIN LIN wakes (channel 0 first), then NUM_LOCAL local wake bits, and the top bit cyclic. With the defaults this is [0] CAN, [2:1] LIN, [4:3] local, [5] cyclic. A status bit is set one cycle after its event pulse.
- R5: A write-1 clear of a CAN or LIN wake status bit leaves that channel's pending flag set. `wake_pending` bit 0 is CAN, and bits 1..NUM_LIN are the LIN channels.
- R6: On the first cycle of Normal mode after any other mode, a pending flag is cleared if its standby control bit is 0 and kept if that bit is 1. Mode encoding on `sys_mode`: 00 Standby, 01 Normal, 10 Sleep, 11 Overtemp.
- R7: The cyclic source is armed when `wd_mode` changes to timeout (01) while `sys_mode` is Standby or Normal and `wd_off`=0. While armed, each `wd_overflow` pulse sets the cyclic bit. `wd_mode` encoding: 00 window, 01 timeout, 10 disabled.
- R8: The cyclic source is not armed if `wd_off`=1 or the system is in Sleep or Overtemp when timeout is entered. In that case overflow pulses leave the cyclic bit at 0.
- R9: Arming is lost once `wd_mode` leaves timeout. It comes back only through a new qualifying entry as in R7.
- R10: After reset all status bits and pending flags are 0 and the interrupt line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_mode | input | 2 | System mode (00 Standby, 01 Normal, 10 Sleep, 11 Overtemp) |
| stby_can | input | 1 | CAN standby control bit |
| stby_lin | input | NUM_LIN | LIN standby control bits, one per channel |
| can_wake_evt | input | 1 | CAN wake event pulse |
| lin_wake_evt | input | NUM_LIN | LIN wake event pulses |
| local_wake_evt | input | NUM_LOCAL | Qualified local wake pin event pulses |
| wd_mode | input | 2 | Watchdog mode (00 window, 01 timeout, 10 disabled) |
| wd_off | input | 1 | Watchdog-off input, active high |
| wd_overflow | input | 1 | Watchdog overflow pulse |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | NUM_LIN+NUM_LOCAL+2 | Write data, 1 clears the bit |
| reg_rdata | output | NUM_LIN+NUM_LOCAL+2 | Current status bits |
| wake_pending | output | NUM_LIN+1 | Pending-wake flags (bit 0 CAN, then LIN) |
| irq_pull_low | output | 1 | Open-drain enable of the interrupt line, 1 pulls low |

## Verification
The assertions check several rules on every cycle: a set always wins over a clear, a clear with no set empties a bit, and a bit with no set and no clear holds its value. They also check that a pending flag survives every cycle that is not a qualifying Normal entry, that such an entry drops it, and that the cyclic arm falls whenever the watchdog is off or leaves timeout. Some behaviours need a sequence of events and only the directed scenarios show them. These are acknowledging a wake in Standby and then entering Normal with the standby bit both 0 and 1, arming the cyclic source and counting repeated overflows, and the refusal to arm from Sleep or after the arm has been dropped.

// File: rtl/isc_pkg.sv
// Package: shared encodings for the interrupt status controller.
// Assumes the mode inputs arrive as plain 2-bit codes from their owners.
package isc_pkg;

    typedef enum logic [1:0] {
        SM_STANDBY  = 2'b00,
        SM_NORMAL   = 2'b01,
        SM_SLEEP    = 2'b10,
        SM_OVERTEMP = 2'b11
    } sys_mode_e;

    typedef enum logic [1:0] {
        WDM_WINDOW   = 2'b00,
        WDM_TIMEOUT  = 2'b01,
        WDM_DISABLED = 2'b10
    } wd_mode_e;

    // True for the modes in which the cyclic source may be armed
    function automatic logic mode_allows_cyclic(input sys_mode_e m);
        return (m == SM_STANDBY) || (m == SM_NORMAL);
    endfunction

endpackage

// File: rtl/isc_status_bit.sv
// Module: one write-1-to-clear status bit.
// What it does: a set pulse forces the bit to 1, a clear request forces it
// to 0, and a set takes priority over a clear in the same cycle.
// Assumes: set and clr are synchronous to clk.
module isc_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Status flop: the set has priority, then the clear, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_WINS:  assert property (@(posedge clk) disable iff (!rst_n) set |=> q);                   // R3
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n) (clr && !set) |=> !q);        // R2
    AST_HOLD_BIT:  assert property (@(posedge clk) disable iff (!rst_n) (!set && !clr) |=> $stable(q)); // R2

endmodule

// File: rtl/isc_wake_pending.sv
// Module: pending-wake flag of one CAN or LIN channel.
// What it does: a wake event sets the flag. The flag is dropped only on
// entry into Normal mode with the channel's standby control bit at 0.
// Status-bit clears never reach this flag.
// Assumes: normal_entry is high for exactly the first Normal cycle.
module isc_wake_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic normal_entry,
    input  logic stby_bit,
    output logic pend
);

    logic drop;
    assign drop = normal_entry && !stby_bit;

    // Pending flop: a new wake wins over a Normal-entry drop
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (wake_evt) pend <= 1'b1;
        else if (drop)     pend <= 1'b0;
    end

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(normal_entry && !stby_bit)) |=> pend);                  // R5
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_entry && !stby_bit && !wake_evt) |=> !pend);               // R6

endmodule

// File: rtl/isc_cyclic_ctrl.sv
// Module: arming logic of the watchdog cyclic interrupt.
// What it does: arms when the watchdog moves into timeout while the system
// is in Standby or Normal and the watchdog-off input is low. Disarms when
// the watchdog-off input is high or the watchdog leaves timeout. Passes
// overflow pulses on as cyclic set pulses while armed.
// Assumes: wd_overflow is a single-cycle pulse from the watchdog counter.
module isc_cyclic_ctrl
    import isc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sys_mode_e sys_mode,
    input  wd_mode_e  wd_mode,
    input  logic      wd_off,
    input  logic      wd_overflow,
    output logic      ci_set
);

    wd_mode_e wd_prev;
    logic     ci_armed;
    logic     in_timeout;
    logic     timeout_entry;

    assign in_timeout    = (wd_mode == WDM_TIMEOUT);
    assign timeout_entry = in_timeout && (wd_prev != WDM_TIMEOUT);

    // Remember the previous watchdog mode to find the entry into timeout
    always_ff @(posedge clk) begin
        if (!rst_n) wd_prev <= WDM_WINDOW;
        else        wd_prev <= wd_mode;
    end

    // Arm flop: cleared by wd_off or leaving timeout, set on a qualifying entry
    always_ff @(posedge clk) begin
        if (!rst_n)
            ci_armed <= 1'b0;
        else if (wd_off || !in_timeout)
            ci_armed <= 1'b0;
        else if (timeout_entry && mode_allows_cyclic(sys_mode))
            ci_armed <= 1'b1;
    end

    // Forward an overflow only while armed and still in timeout
    always_comb ci_set = wd_overflow && ci_armed && in_timeout;

    AST_CI_OFF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) wd_off |=> !ci_armed);       // R8
    AST_CI_LEAVE:     assert property (@(posedge clk) disable iff (!rst_n) !in_timeout |=> !ci_armed);  // R9
    AST_CI_SLEEP:     assert property (@(posedge clk) disable iff (!rst_n)
        (!ci_armed && !mode_allows_cyclic(sys_mode)) |=> !ci_armed);                                    // R8

endmodule

// File: rtl/isc_irq_ctrl.sv
// Module: top of the wake-aware interrupt status controller.
// What it does: collects wake, local-wake and cyclic events into
// write-1-to-clear status bits. It keeps pending-wake flags for CAN and LIN
// and drives the open-drain enable of the interrupt line.
// Assumes: event inputs are single-cycle pulses already synchronised to clk.
module isc_irq_ctrl
    import isc_pkg::*;
#(
    parameter int NUM_LIN   = 2,
    parameter int NUM_LOCAL = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     sys_mode,
    input  logic                           stby_can,
    input  logic [NUM_LIN-1:0]             stby_lin,
    input  logic                           can_wake_evt,
    input  logic [NUM_LIN-1:0]             lin_wake_evt,
    input  logic [NUM_LOCAL-1:0]           local_wake_evt,
    input  logic [1:0]                     wd_mode,
    input  logic                           wd_off,
    input  logic                           wd_overflow,
    input  logic                           reg_wr,
    input  logic [NUM_LIN+NUM_LOCAL+1:0]   reg_wdata,
    output logic [NUM_LIN+NUM_LOCAL+1:0]   reg_rdata,
    output logic [NUM_LIN:0]               wake_pending,
    output logic                           irq_pull_low
);

    localparam int STAT_W = NUM_LIN + NUM_LOCAL + 2;
    localparam int PEND_W = NUM_LIN + 1;

    sys_mode_e         mode_now;
    sys_mode_e         mode_prev;
    logic              normal_entry;
    logic              ci_set;
    logic [STAT_W-1:0] evt_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status;
    logic [PEND_W-1:0] stby_vec;

    assign mode_now = sys_mode_e'(sys_mode);

    // Track the previous system mode to find the first Normal cycle
    always_ff @(posedge clk) begin
        if (!rst_n) mode_prev <= SM_STANDBY;
        else        mode_prev <= mode_now;
    end

    assign normal_entry = (mode_now == SM_NORMAL) && (mode_prev != SM_NORMAL);

    // Gather set pulses and clear requests in register bit order
    always_comb begin
        evt_vec  = {ci_set, local_wake_evt, lin_wake_evt, can_wake_evt};
        clr_vec  = reg_wr ? reg_wdata : '0;
        stby_vec = {stby_lin, stby_can};
    end

    isc_cyclic_ctrl u_cyclic (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_mode    (mode_now),
        .wd_mode     (wd_mode_e'(wd_mode)),
        .wd_off      (wd_off),
        .wd_overflow (wd_overflow),
        .ci_set      (ci_set)
    );

    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        isc_status_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (evt_vec[i]),
            .clr   (clr_vec[i]),
            .q     (status[i])
        );
    end

    for (genvar j = 0; j < PEND_W; j++) begin : g_pend
        isc_wake_pending u_pend (
            .clk          (clk),
            .rst_n        (rst_n),
            .wake_evt     (evt_vec[j]),
            .normal_entry (normal_entry),
            .stby_bit     (stby_vec[j]),
            .pend         (wake_pending[j])
        );
    end

    // Register read path and open-drain enable of the interrupt line
    always_comb begin
        reg_rdata    = status;
        irq_pull_low = |status;
    end

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n) (|evt_vec) |=> irq_pull_low); // R1
    AST_IRQ_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_vec == '0) && reg_wr && (&reg_wdata)) |=> !irq_pull_low);                                  // R1

endmodule

// File: tb/test_isc_irq_ctrl.sv
module test_isc_irq_ctrl;

    localparam int NL = 2;
    localparam int NC = 2;
    localparam int SW = NL + NC + 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    sys_mode;
    logic          stby_can;
    logic [NL-1:0] stby_lin;
    logic          can_wake_evt;
    logic [NL-1:0] lin_wake_evt;
    logic [NC-1:0] local_wake_evt;
    logic [1:0]    wd_mode;
    logic          wd_off;
    logic          wd_overflow;
    logic          reg_wr;
    logic [SW-1:0] reg_wdata;
    logic [SW-1:0] reg_rdata;
    logic [NL:0]   wake_pending;
    logic          irq_pull_low;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    isc_irq_ctrl #(.NUM_LIN(NL), .NUM_LOCAL(NC)) i_isc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .stby_can(stby_can),
        .stby_lin(stby_lin), .can_wake_evt(can_wake_evt), .lin_wake_evt(lin_wake_evt),
        .local_wake_evt(local_wake_evt), .wd_mode(wd_mode), .wd_off(wd_off),
        .wd_overflow(wd_overflow), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wake_pending(wake_pending), .irq_pull_low(irq_pull_low)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        reg_wr = 1'b1; reg_wdata = '1;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        check("R10", reg_rdata, 0, "status after reset");
        check("R10", wake_pending, 0, "pending after reset");
        check("R10", irq_pull_low, 0, "irq after reset");
    endtask

    task automatic t_set_clear();
        sys_mode = 2'b01;
        can_wake_evt = 1'b1; local_wake_evt = 2'b10;
        cyc();
        can_wake_evt = 1'b0; local_wake_evt = '0;
        check("R4", reg_rdata, 6'b010001, "CAN and local1 set");
        check("R1", irq_pull_low, 1, "irq asserted");
        reg_wr = 1'b1; reg_wdata = '0;
        cyc();
        reg_wr = 1'b0;
        check("R2", reg_rdata, 6'b010001, "write 0 keeps bits");
        reg_wr = 1'b1; reg_wdata = 6'b000001;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
        check("R2", reg_rdata, 6'b010000, "write 1 clears CAN only");
        check("R1", irq_pull_low, 1, "irq still asserted");
        reg_wr = 1'b1; reg_wdata = 6'b010000;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
        check("R1", irq_pull_low, 0, "irq released when empty");
    endtask

    task automatic t_collision();
        lin_wake_evt = 2'b01;
        reg_wr = 1'b1; reg_wdata = 6'b000010;
        cyc();
        lin_wake_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        check("R3", reg_rdata, 6'b000010, "event beats clear");
        clear_all();
    endtask

    task automatic t_standby_pending();
        sys_mode = 2'b00; stby_lin = 2'b00; stby_can = 1'b1;
        cyc();
        lin_wake_evt = 2'b01; can_wake_evt = 1'b1;
        cyc();
        lin_wake_evt = '0; can_wake_evt = 1'b0;
        check("R4", reg_rdata, 6'b000011, "LIN0 and CAN set");
        clear_all();
        check("R5", reg_rdata, 0, "status cleared in standby");
        check("R5", wake_pending, 3'b011, "pending kept after clear");
        sys_mode = 2'b01;
        cyc();
        check("R6", wake_pending, 3'b001, "LIN0 dropped, CAN kept (stby=1)");
        cyc();
        check("R6", wake_pending, 3'b001, "no drop while staying Normal");
        stby_can = 1'b0; sys_mode = 2'b00;
        cyc();
        sys_mode = 2'b01;
        cyc();
        check("R6", wake_pending, 0, "CAN dropped on new entry");
    endtask

    task automatic t_cyclic();
        sys_mode = 2'b00; wd_mode = 2'b00;
        cyc();
        wd_mode = 2'b01;
        cyc();
        wd_overflow = 1'b1;
        cyc();
        wd_overflow = 1'b0;
        check("R7", reg_rdata, 6'b100000, "cyclic set on overflow");
        clear_all();
        check("R7", reg_rdata, 0, "cyclic cleared");
        wd_overflow = 1'b1;
        cyc();
        wd_overflow = 1'b0;
        check("R7", reg_rdata, 6'b100000, "cyclic set on second overflow");
        clear_all();
    endtask

    task automatic t_no_arm();
        wd_mode = 2'b00;
        cyc();
        wd_off = 1'b1; wd_mode = 2'b01;
        cyc();
        wd_off = 1'b0;
        wd_overflow = 1'b1;
        cyc();
        wd_overflow = 1'b0;
        check("R8", reg_rdata, 0, "no arm with wd_off");
        wd_mode = 2'b00;
        cyc();
        sys_mode = 2'b10; wd_mode = 2'b01;
        cyc();
        wd_overflow = 1'b1;
        cyc();
        wd_overflow = 1'b0;
        check("R8", reg_rdata, 0, "no arm from Sleep");
        check("R8", irq_pull_low, 0, "irq stays released");
    endtask

    task automatic t_disarm();
        sys_mode = 2'b00; wd_mode = 2'b00;
        cyc();
        wd_mode = 2'b01;
        cyc();
        wd_mode = 2'b10;
        cyc();
        sys_mode = 2'b10; wd_mode = 2'b01;
        cyc();
        wd_overflow = 1'b1;
        cyc();
        wd_overflow = 1'b0;
        check("R9", reg_rdata, 0, "arm lost after leaving timeout");
    endtask

    initial begin
        rst_n = 1'b0; sys_mode = 2'b00; stby_can = 1'b0; stby_lin = '0;
        can_wake_evt = 1'b0; lin_wake_evt = '0; local_wake_evt = '0;
        wd_mode = 2'b00; wd_off = 1'b0; wd_overflow = 1'b0;
        reg_wr = 1'b0; reg_wdata = '0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_set_clear();
        t_collision();
        t_standby_pending();
        t_cyclic();
        t_no_arm();
        t_disarm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule